// File: doc/BRIEF.md
# Vector Predicate-Result Writeback Sequencer

This block steps through the elements of one vectorised operation, one element at most per clock. A start pulse captures the vector length (0 to `MAX_VL`), the per-element predicate mask, the condition-store flag, the condition-only mode flag, a 3-bit branch-style test selector, and the base addresses of a condition-field file and an integer register file. Elements whose predicate bit is clear are passed over. No result is taken for them and nothing is written.

For an active element the block takes a computed result from a valid/ready input. From that result it forms a 4-bit condition field holding less-than, greater-than, equal and an overflow-summary bit. In the same cycle it decides two things on its own. The first is whether to write the condition field to the condition file at its base plus the element index. The second is whether to write the result to the integer file at its base plus the element index. The result write passes only if the selected condition bit equals the expected value and condition-only mode is off. So the condition field can be stored even when the result is suppressed.

A one-cycle done pulse marks the end of the operation. The datapath that produces results and the instruction decode sit outside the block.

Top module: `predWbSeq`

## Requirements
- R1: While reset is applied and just after it, `busy`, `done`, `resReady`, `crWrEn` and `rfWrEn` are all low.
- R2: A `start` pulse while idle captures `vecLen`, `predMask`, `rcFlag`, `rc1Mode`, `testSel`, `crBase` and `rtBase`, and `busy` is high from the next cycle. A `start` pulse while busy is ignored, and the captured configuration of the running operation is kept.
- R3: An element i with `predMask[i]` = 0 takes exactly one cycle. During that cycle `resReady`, `crWrEn` and `rfWrEn` stay low.
- R4: For an element i with `predMask[i]` = 1, `resReady` is high until `resValid` is seen. Elements are handled in increasing index order. Both write decisions are made in the handshake cycle, and at most one result is taken per clock.
- R5: The condition field `crWrData` is {lt, gt, eq, so} in bits 3 down to 0. lt means the result is negative as a signed two's complement value, eq means it is zero, gt means neither, and so copies `soIn` from the handshake cycle.
- R6: The condition field is written, with `crWrEn` high and `crWrAddr` = `crBase` + i modulo 2^`AW`, in the handshake cycle exactly when `rcFlag` or `rc1Mode` was captured high.
- R7: `testSel[2:1]` picks a bit of the new condition field: 0 picks lt, 1 picks gt, 2 picks eq and 3 picks so. `testSel[0]` is the value that bit must hold. When the bit matches and `rc1Mode` is clear, the result is written in the handshake cycle, with `rfWrEn` high, `rfWrAddr` = `rtBase` + i modulo 2^`AW` and `rfWrData` equal to the result. Otherwise no result write occurs, and the condition write of R6 is unaffected.
- R8: With `rc1Mode` captured high, no result write occurs for any element, and every active element writes its condition field.
- R9: `done` is high for exactly one cycle, the cycle after element `vecLen`-1 has been handled. `busy` is low on the following cycle.
- R10: With `vecLen` = 0, `done` is high in the cycle after `start`. `resReady`, `crWrEn` and `rfWrEn` stay low throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| vecLen | input | VL_W | Number of elements, 0 to MAX_VL |
| predMask | input | MAX_VL | Predicate bit per element, 1 = active |
| rcFlag | input | 1 | Store condition field for active elements |
| rc1Mode | input | 1 | Condition-only mode: store condition, never result |
| testSel | input | 3 | [2:1] condition bit select, [0] expected value |
| crBase | input | AW | Condition file base address |
| rtBase | input | AW | Integer file base address |
| resValid | input | 1 | Result for the current element is offered |
| resData | input | DATA_W | Computed result |
| soIn | input | 1 | Summary-overflow flag accompanying the result |
| resReady | output | 1 | Block takes the result this cycle if valid |
| crWrEn | output | 1 | Condition file write enable |
| crWrAddr | output | AW | Condition file write address |
| crWrData | output | 4 | Condition field {lt, gt, eq, so} |
| rfWrEn | output | 1 | Integer file write enable |
| rfWrAddr | output | AW | Integer file write address |
| rfWrData | output | DATA_W | Result to store |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Results cycle through zero, small negative, positive and large positive values, and the overflow flag toggles. Every value of the test selector therefore meets both a matching and a mismatching condition bit, which separates a wrong bit pick from a wrong polarity. Sparse masks tell skipping apart from consuming. Runs with and without producer stalls expose any write that is not tied to the handshake. Operations with the condition store off, on, and in condition-only mode show that the two write decisions stay independent. A zero-length run, a full 64-element run with address wrap, and a start pulse in mid-run cover the edges of the sequencing.

// File: rtl/predWbPkg.sv
package predWbPkg;
  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic load;    // capture configuration this cycle
    logic accept;  // result handshake completes this cycle
    logic finish;  // index has reached the vector length
  } seqStrobes_t;
endpackage

// File: rtl/predWbCtrl.sv
module predWbCtrl
  import predWbPkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int VL_W   = $clog2(MAX_VL + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [VL_W-1:0] vecLen,
  input  logic            maskBit,
  input  logic            resValid,
  output seqStrobes_t     strobes,
  output logic [VL_W-1:0] idx,
  output logic            resReady,
  output logic            busy,
  output logic            done
);
  localparam logic [VL_W-1:0] VL_LIMIT = VL_W'(MAX_VL);

  logic            running;
  logic [VL_W-1:0] vlLat;
  logic [VL_W-1:0] vlIn;
  logic            atEnd;
  logic            wantRes;
  logic            skipNow;

  assign vlIn    = (vecLen > VL_LIMIT) ? VL_LIMIT : vecLen;
  assign atEnd   = running && (idx == vlLat);
  assign wantRes = running && !atEnd && maskBit;
  assign skipNow = running && !atEnd && !maskBit;

  assign strobes.load   = !running && start;
  assign strobes.accept = wantRes && resValid;
  assign strobes.finish = atEnd;

  assign resReady = wantRes;
  assign busy     = running;
  assign done     = atEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      idx     <= '0;
      vlLat   <= '0;
    end else if (strobes.load) begin
      running <= 1'b1;
      idx     <= '0;
      vlLat   <= vlIn;
    end else if (atEnd) begin
      running <= 1'b0;
    end else if (skipNow || strobes.accept) begin
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/predWbDatapath.sv
module predWbDatapath
  import predWbPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int MAX_VL = 64,
  parameter int VL_W   = $clog2(MAX_VL + 1),
  parameter int AW     = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [VL_W-1:0]   idx,
  input  logic [MAX_VL-1:0] predMask,
  input  logic              rcFlag,
  input  logic              rc1Mode,
  input  logic [2:0]        testSel,
  input  logic [AW-1:0]     crBase,
  input  logic [AW-1:0]     rtBase,
  input  logic [DATA_W-1:0] resData,
  input  logic              soIn,
  output logic              maskBit,
  output logic              crWrEn,
  output logic [AW-1:0]     crWrAddr,
  output logic [3:0]        crWrData,
  output logic              rfWrEn,
  output logic [AW-1:0]     rfWrAddr,
  output logic [DATA_W-1:0] rfWrData
);
  localparam int IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1;
  localparam logic [VL_W-1:0] VL_LIMIT = VL_W'(MAX_VL);

  logic [MAX_VL-1:0] maskLat;
  logic              rcLat;
  logic              rc1Lat;
  logic [2:0]        selLat;
  logic [AW-1:0]     crBaseLat;
  logic [AW-1:0]     rtBaseLat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskLat   <= '0;
      rcLat     <= 1'b0;
      rc1Lat    <= 1'b0;
      selLat    <= '0;
      crBaseLat <= '0;
      rtBaseLat <= '0;
    end else if (strobes.load) begin
      maskLat   <= predMask;
      rcLat     <= rcFlag;
      rc1Lat    <= rc1Mode;
      selLat    <= testSel;
      crBaseLat <= crBase;
      rtBaseLat <= rtBase;
    end
  end

  // Predicate bit of the current element
  always_comb begin
    maskBit = 1'b0;
    if (!strobes.finish && (idx < VL_LIMIT))
      maskBit = maskLat[idx[IDX_W-1:0]];
  end

  // Condition field from the signed result
  logic isNeg, isZero, isPos;
  logic [3:0] condField;
  assign isNeg     = resData[DATA_W-1];
  assign isZero    = (resData == '0);
  assign isPos     = !isNeg && !isZero;
  assign condField = {isNeg, isPos, isZero, soIn};

  // Branch-style test of one condition bit
  logic pickedBit;
  always_comb begin
    case (selLat[2:1])
      2'd0:    pickedBit = condField[3];
      2'd1:    pickedBit = condField[2];
      2'd2:    pickedBit = condField[1];
      default: pickedBit = condField[0];
    endcase
  end

  logic testPass;
  assign testPass = (pickedBit == selLat[0]);

  assign crWrEn   = strobes.accept && (rcLat || rc1Lat);
  assign crWrAddr = crBaseLat + AW'(idx);
  assign crWrData = condField;

  assign rfWrEn   = strobes.accept && !rc1Lat && testPass;
  assign rfWrAddr = rtBaseLat + AW'(idx);
  assign rfWrData = resData;
endmodule

// File: rtl/predWbSeq.sv
module predWbSeq
  import predWbPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int MAX_VL = 64,
  parameter int VL_W   = $clog2(MAX_VL + 1),
  parameter int AW     = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [VL_W-1:0]   vecLen,
  input  logic [MAX_VL-1:0] predMask,
  input  logic              rcFlag,
  input  logic              rc1Mode,
  input  logic [2:0]        testSel,
  input  logic [AW-1:0]     crBase,
  input  logic [AW-1:0]     rtBase,
  input  logic              resValid,
  input  logic [DATA_W-1:0] resData,
  input  logic              soIn,
  output logic              resReady,
  output logic              crWrEn,
  output logic [AW-1:0]     crWrAddr,
  output logic [3:0]        crWrData,
  output logic              rfWrEn,
  output logic [AW-1:0]     rfWrAddr,
  output logic [DATA_W-1:0] rfWrData,
  output logic              busy,
  output logic              done
);
  seqStrobes_t     strobes;
  logic [VL_W-1:0] idx;
  logic            maskBit;

  predWbCtrl #(.MAX_VL(MAX_VL), .VL_W(VL_W)) ctrl (
    .clk(clk), .rstN(rstN), .start(start), .vecLen(vecLen),
    .maskBit(maskBit), .resValid(resValid), .strobes(strobes),
    .idx(idx), .resReady(resReady), .busy(busy), .done(done)
  );

  predWbDatapath #(.DATA_W(DATA_W), .MAX_VL(MAX_VL), .VL_W(VL_W), .AW(AW)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .idx(idx),
    .predMask(predMask), .rcFlag(rcFlag), .rc1Mode(rc1Mode),
    .testSel(testSel), .crBase(crBase), .rtBase(rtBase),
    .resData(resData), .soIn(soIn), .maskBit(maskBit),
    .crWrEn(crWrEn), .crWrAddr(crWrAddr), .crWrData(crWrData),
    .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr), .rfWrData(rfWrData)
  );
endmodule

// File: rtl/predWbChecker.sv
module predWbChecker #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              resValid,
  input logic              resReady,
  input logic              crWrEn,
  input logic [3:0]        crWrData,
  input logic              rfWrEn,
  input logic [DATA_W-1:0] rfWrData,
  input logic [DATA_W-1:0] resData,
  input logic              busy,
  input logic              done
);
  // R1: outputs quiet during reset
  always_ff @(posedge clk)
    if (!rstN) assert_quiet_in_reset_R1:
      assert (!busy && !done && !resReady && !crWrEn && !rfWrEn);

  // R2: a start while idle makes the block busy next cycle
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R4: a result is written only in a handshake cycle, unchanged
  assert_rf_needs_handshake_R4: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> (resValid && resReady && rfWrData == resData));

  // R6: a condition write also needs a handshake
  assert_cr_needs_handshake_R6: assert property (@(posedge clk) disable iff (!rstN)
    crWrEn |-> (resValid && resReady));

  // R5: exactly one of lt, gt, eq is set in a written field
  assert_cond_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    crWrEn |-> ($countones(crWrData[3:1]) == 1));

  // R9: done ends the operation
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R3: handshake ready only while an operation runs
  assert_ready_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    resReady |-> (busy && !done));
endmodule

bind predWbSeq predWbChecker #(.DATA_W(DATA_W)) chk (
  .clk(clk), .rstN(rstN), .start(start), .resValid(resValid),
  .resReady(resReady), .crWrEn(crWrEn), .crWrData(crWrData),
  .rfWrEn(rfWrEn), .rfWrData(rfWrData), .resData(resData),
  .busy(busy), .done(done)
);

// File: tb/predWbSeq_test.sv
`timescale 1ns/1ps
module predWbSeq_test;
  localparam int DATA_W = 64;
  localparam int MAX_VL = 64;
  localparam int VL_W   = $clog2(MAX_VL + 1);
  localparam int AW     = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [VL_W-1:0] vecLen = '0;
  logic [MAX_VL-1:0] predMask = '0;
  logic rcFlag = 1'b0, rc1Mode = 1'b0, soIn = 1'b0, resValid = 1'b0;
  logic [2:0] testSel = '0;
  logic [AW-1:0] crBase = '0, rtBase = '0;
  logic [DATA_W-1:0] resData = '0;
  logic resReady, crWrEn, rfWrEn, busy, done;
  logic [AW-1:0] crWrAddr, rfWrAddr;
  logic [3:0] crWrData;
  logic [DATA_W-1:0] rfWrData;

  int compared = 0;
  int mismatched = 0;

  // behavioural model state
  bit mRun = 0;
  int mIdx = 0, mVl = 0;
  logic [MAX_VL-1:0] mMask;
  bit mRc, mRc1;
  bit [2:0] mSel;
  int mCrB, mRtB;

  always #2.5 clk = ~clk;

  predWbSeq #(.DATA_W(DATA_W), .MAX_VL(MAX_VL), .AW(AW)) uut (
    .clk(clk), .rstN(rstN), .start(start), .vecLen(vecLen),
    .predMask(predMask), .rcFlag(rcFlag), .rc1Mode(rc1Mode),
    .testSel(testSel), .crBase(crBase), .rtBase(rtBase),
    .resValid(resValid), .resData(resData), .soIn(soIn),
    .resReady(resReady), .crWrEn(crWrEn), .crWrAddr(crWrAddr),
    .crWrData(crWrData), .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr),
    .rfWrData(rfWrData), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] dataFor(input int seed, input int i);
    case ((i + seed) % 5)
      0: return 64'd0;
      1: return ~64'(i + 1) + 64'd1;
      2: return 64'(i * 1000 + seed + 1);
      3: return 64'h8000_0000_0000_0000 + 64'(i);
      default: return 64'h7FFF_FFFF_FFFF_FFF0 - 64'(i);
    endcase
  endfunction

  // compare one cycle against the model, then advance the model
  task automatic stepCompare();
    bit atEnd, want, acc, lt, gt, eq, pick;
    bit [3:0] cf;
    bit eCr, eRf;
    atEnd = mRun && (mIdx == mVl);
    want  = mRun && !atEnd && mMask[mIdx];
    acc   = want && resValid;
    lt = $signed(resData) < 0;
    eq = (resData == 0);
    gt = !lt && !eq;
    cf = {lt, gt, eq, soIn};
    case (mSel[2:1])
      2'd0: pick = lt;
      2'd1: pick = gt;
      2'd2: pick = eq;
      default: pick = soIn;
    endcase
    eCr = acc && (mRc || mRc1);
    eRf = acc && !mRc1 && (pick == mSel[0]);
    check(busy == mRun, "R2 busy", busy, mRun);
    check(done == atEnd, (mVl == 0) ? "R10 done" : "R9 done", done, atEnd);
    check(resReady == want, (mRun && !atEnd && !mMask[mIdx]) ? "R3 resReady" : "R4 resReady", resReady, want);
    check(crWrEn == eCr, "R6 crWrEn", crWrEn, eCr);
    check(rfWrEn == eRf, mRc1 ? "R8 rfWrEn" : "R7 rfWrEn", rfWrEn, eRf);
    if (eCr) begin
      check(crWrAddr == AW'(mCrB + mIdx), "R6 crWrAddr", crWrAddr, AW'(mCrB + mIdx));
      check(crWrData == cf, "R5 crWrData", crWrData, cf);
    end
    if (eRf) begin
      check(rfWrAddr == AW'(mRtB + mIdx), "R7 rfWrAddr", rfWrAddr, AW'(mRtB + mIdx));
      check(rfWrData == resData, "R7 rfWrData", rfWrData, resData);
    end
    if (!mRun && start) begin
      mRun = 1; mIdx = 0; mVl = int'(vecLen); mMask = predMask;
      mRc = rcFlag; mRc1 = rc1Mode; mSel = testSel;
      mCrB = int'(crBase); mRtB = int'(rtBase);
    end else if (atEnd) mRun = 0;
    else if (mRun && (!mMask[mIdx] || acc)) mIdx++;
  endtask

  task automatic runOp(input int vl, input logic [MAX_VL-1:0] mask, input bit rc,
                       input bit rc1, input bit [2:0] sel, input int crB,
                       input int rtB, input int seed, input bit stalls, input bit restartMid);
    int cyc = 0;
    bit finished = 0;
    while (!finished) begin
      @(negedge clk);
      if (cyc == 0) begin
        start = 1; vecLen = VL_W'(vl); predMask = mask; rcFlag = rc;
        rc1Mode = rc1; testSel = sel; crBase = AW'(crB); rtBase = AW'(rtB);
      end else if (restartMid && cyc == 3) begin
        // R2: start while busy with a different configuration
        start = 1; vecLen = VL_W'(1); predMask = ~mask; rcFlag = ~rc;
        rc1Mode = ~rc1; testSel = ~sel; crBase = AW'(crB + 9); rtBase = AW'(rtB + 9);
      end else start = 0;
      resValid = !(stalls && (((cyc * 7 + seed) % 5) == 0));
      resData  = dataFor(seed, mIdx);
      soIn     = ((mIdx + seed) % 3) == 0;
      #1;
      if (mRun && mIdx == mVl) finished = 1;
      stepCompare();
      cyc++;
      if (cyc > 400) begin
        mismatched++;
        $display("FAIL watchdog R9 actual=running expected=done");
        finished = 1;
      end
    end
    @(negedge clk);
    start = 0; resValid = 0;
    #1 stepCompare();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check(!busy && !done && !resReady && !crWrEn && !rfWrEn, "R1 reset outputs",
          {busy, done, resReady, crWrEn, rfWrEn}, 0);
    @(negedge clk); rstN = 1;
    #1 check(!busy && !done, "R1 after reset", {busy, done}, 0);
    runOp(8, 64'hFF, 1, 0, 3'b101, 10, 20, 0, 0, 0);            // eq must be 1
    runOp(8, 64'hFF, 1, 0, 3'b001, 3, 5, 1, 1, 0);              // lt must be 1, stalls
    runOp(12, 64'b1011_0110_1001, 0, 0, 3'b000, 0, 40, 2, 1, 0); // sparse, lt must be 0
    runOp(10, 64'h3FF, 0, 0, 3'b011, 7, 9, 3, 1, 0);            // gt must be 1
    runOp(10, 64'h2F5, 1, 0, 3'b110, 7, 9, 4, 0, 0);            // so must be 0
    runOp(9, 64'h1FF, 0, 1, 3'b101, 100, 0, 1, 1, 0);           // R8 condition-only
    runOp(0, 64'hFF, 1, 0, 3'b000, 0, 0, 0, 0, 0);              // R10 zero length
    runOp(64, '1, 1, 0, 3'b111, 126, 120, 2, 1, 0);             // full length, wrap
    runOp(10, 64'h3BF, 1, 0, 3'b100, 5, 6, 3, 1, 1);            // R2 start in mid-run
    runOp(4, 64'h0, 1, 0, 3'b000, 5, 6, 0, 0, 0);               // R3 all masked
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #200000;
    mismatched++;
    $display("FAIL global watchdog R9 actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule